// File: doc/BRIEF.md
# Overlay Control Register File

This block is the software-visible control bank of a multi-layer display overlay engine. A simple 32-bit register port writes and reads the settings that steer the engine. The global settings are the frame-done interrupt enable and its status, the engine run bit, the soft reset, the region-of-interest size, the background colour and a mask that turns individual layers on. A bank of control, source size, offset and pitch settings is repeated for each layer at a fixed address stride. Every setting is also driven out as a plain output for the overlay datapath.

The engine reports the end of each frame with a one-cycle `frame_done_i` pulse. That pulse sets a sticky status flag. The flag drives `irq_o` only while its enable bit is set. Software clears the flag by writing zero to the status register. Reads return data one clock after the read strobe. The layer count is a parameter, and any address outside the decoded set behaves as empty space.

Top module: `lmx_csr`

## Requirements
- R1: While reset is asserted, and until the first write after it, every register reads zero and `irq_o`, `engine_en_o`, `soft_rst_o` and all layer outputs are zero. `bus_rdata` is zero after reset.
- R2: `bus_rdata` takes the value of the addressed register on the clock edge at which `bus_ren` is high, and holds its value while `bus_ren` is low. A read and a write to the same address in one cycle return the value from before the write.
- R3: The interrupt enable register is at byte address 0x04 and keeps only bit 1 (all other bits read zero). The interrupt status register is at 0x08 and reports the frame-done flag in bit 1.
- R4: A `frame_done_i` pulse sets the status flag whatever the enable bit holds. `irq_o` is high exactly when both the flag and the enable bit are set.
- R5: A write to 0x08 with bit 1 equal to 0 clears the flag, and a write with bit 1 equal to 1 leaves it unchanged. If `frame_done_i` arrives in the same cycle as a clearing write, the flag stays set.
- R6: Bit 0 of the register at 0x0C is the engine run bit and drives `engine_en_o`. Bit 0 of the register at 0x14 is the soft reset and drives `soft_rst_o`. The other bits of both registers read zero.
- R7: The region-of-interest size at 0x20 (height in bits 31:16, width in bits 15:0) and the background colour at 0x28 keep all 32 bits and drive `roi_size_o` and `bg_color_o`.
- R8: The layer enable mask at 0x2C keeps bits NUM_LAYERS-1:0, where bit n drives `src_en_o[n]`. Higher bits read zero. A rewrite changes only the bits whose value differs.
- R9: Layer n has its bank at base 0x30 + 0x20*n: control at +0x00, source size at +0x08 and offset at +0x0C (all 32 bits, Y or height in bits 31:16, X or width in bits 15:0), and pitch at +0x14 (bits 15:0 only). Each bank drives its slice n of the flattened layer outputs.
- R10: Any other address reads zero and a write to it changes nothing. This covers gaps, unaligned addresses and banks at or above NUM_LAYERS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| frame_done_i | input | 1 | One-cycle end-of-frame pulse from the engine |
| irq_o | output | 1 | Frame-done interrupt |
| engine_en_o | output | 1 | Engine run bit |
| soft_rst_o | output | 1 | Engine soft reset |
| roi_size_o | output | 32 | Region-of-interest height and width |
| bg_color_o | output | 32 | Background colour |
| src_en_o | output | NUM_LAYERS | Per-layer enable mask |
| layer_ctrl_o | output | 32*NUM_LAYERS | Layer control words, layer n in slice n |
| layer_size_o | output | 32*NUM_LAYERS | Layer source sizes |
| layer_offs_o | output | 32*NUM_LAYERS | Layer offsets |
| layer_pitch_o | output | 16*NUM_LAYERS | Layer pitches |

## Verification
The status flag has two sources: the engine pulse that sets it and a software write of zero that clears it. Both can land on the same clock edge. The bench drives `frame_done_i` together with a clearing write to 0x08 in one cycle. It then expects the flag to read back set and `irq_o` to stay high, because an event must never be lost to a clear. Separate cycles where each source acts alone show that each one works on its own.

// File: rtl/lmx_csr_pkg.sv
package lmx_csr_pkg;

  // Byte offsets of the global registers
  localparam int unsigned OFF_IRQ_EN  = 'h04;
  localparam int unsigned OFF_IRQ_STS = 'h08;
  localparam int unsigned OFF_RUN     = 'h0C;
  localparam int unsigned OFF_SRST    = 'h14;
  localparam int unsigned OFF_ROI     = 'h20;
  localparam int unsigned OFF_BG      = 'h28;
  localparam int unsigned OFF_SRC_EN  = 'h2C;

  // Layer banks: base, stride and offsets inside a bank
  localparam int unsigned LAYER_BASE   = 'h30;
  localparam int unsigned LAYER_STRIDE_LOG2 = 5;
  localparam logic [4:0]  SUB_CTRL  = 5'h00;
  localparam logic [4:0]  SUB_SIZE  = 5'h08;
  localparam logic [4:0]  SUB_OFFS  = 5'h0C;
  localparam logic [4:0]  SUB_PITCH = 5'h14;

  // Status and enable bit position of the frame-done event
  localparam int unsigned FD_BIT = 1;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IRQ_EN,
    SEL_IRQ_STS,
    SEL_RUN,
    SEL_SRST,
    SEL_ROI,
    SEL_BG,
    SEL_SRC_EN,
    SEL_L_CTRL,
    SEL_L_SIZE,
    SEL_L_OFFS,
    SEL_L_PITCH
  } csr_sel_e;

endpackage

// File: rtl/lmx_csr_decode.sv
module lmx_csr_decode
  import lmx_csr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_LAYERS = 4,
  localparam int LIDX_W    = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel,
  output logic [LIDX_W-1:0] lidx
);

  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] bank;
  logic              in_layers;

  always_comb begin
    offs      = addr - ADDR_W'(LAYER_BASE);
    bank      = offs >> LAYER_STRIDE_LOG2;
    in_layers = (addr >= ADDR_W'(LAYER_BASE)) && (bank < ADDR_W'(NUM_LAYERS));
    lidx      = bank[LIDX_W-1:0];
    sel       = SEL_NONE;
    if (in_layers) begin
      unique case (offs[4:0])
        SUB_CTRL:  sel = SEL_L_CTRL;
        SUB_SIZE:  sel = SEL_L_SIZE;
        SUB_OFFS:  sel = SEL_L_OFFS;
        SUB_PITCH: sel = SEL_L_PITCH;
        default:   sel = SEL_NONE;
      endcase
    end else begin
      if (addr == ADDR_W'(OFF_IRQ_EN))  sel = SEL_IRQ_EN;
      if (addr == ADDR_W'(OFF_IRQ_STS)) sel = SEL_IRQ_STS;
      if (addr == ADDR_W'(OFF_RUN))     sel = SEL_RUN;
      if (addr == ADDR_W'(OFF_SRST))    sel = SEL_SRST;
      if (addr == ADDR_W'(OFF_ROI))     sel = SEL_ROI;
      if (addr == ADDR_W'(OFF_BG))      sel = SEL_BG;
      if (addr == ADDR_W'(OFF_SRC_EN))  sel = SEL_SRC_EN;
    end
  end

endmodule

// File: rtl/lmx_csr_global.sv
module lmx_csr_global
  import lmx_csr_pkg::*;
#(
  parameter int NUM_LAYERS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  csr_sel_e              sel,
  input  logic [31:0]           wdata,
  input  logic                  frame_done_i,
  output logic                  irq_en_q,
  output logic                  irq_sts_q,
  output logic                  run_q,
  output logic                  srst_q,
  output logic [31:0]           roi_q,
  output logic [31:0]           bg_q,
  output logic [NUM_LAYERS-1:0] src_en_q,
  output logic                  irq_o
);

  logic ld_ien, ld_run, ld_srst, ld_roi, ld_bg, ld_src, clr_sts;
  logic                  irq_en_d, irq_sts_d, run_d, srst_d;
  logic [31:0]           roi_d, bg_d;
  logic [NUM_LAYERS-1:0] src_en_d;

  always_comb begin
    ld_ien  = wr_en && (sel == SEL_IRQ_EN);
    ld_run  = wr_en && (sel == SEL_RUN);
    ld_srst = wr_en && (sel == SEL_SRST);
    ld_roi  = wr_en && (sel == SEL_ROI);
    ld_bg   = wr_en && (sel == SEL_BG);
    ld_src  = wr_en && (sel == SEL_SRC_EN);
    clr_sts = wr_en && (sel == SEL_IRQ_STS) && !wdata[FD_BIT];

    irq_en_d = ld_ien  ? wdata[FD_BIT] : irq_en_q;
    run_d    = ld_run  ? wdata[0]      : run_q;
    srst_d   = ld_srst ? wdata[0]      : srst_q;
    roi_d    = ld_roi  ? wdata         : roi_q;
    bg_d     = ld_bg   ? wdata         : bg_q;
    src_en_d = ld_src  ? wdata[NUM_LAYERS-1:0] : src_en_q;

    // an arriving event outranks a software clear
    irq_sts_d = irq_sts_q;
    if (clr_sts)      irq_sts_d = 1'b0;
    if (frame_done_i) irq_sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q  <= 1'b0;
      irq_sts_q <= 1'b0;
      run_q     <= 1'b0;
      srst_q    <= 1'b0;
      roi_q     <= '0;
      bg_q      <= '0;
      src_en_q  <= '0;
    end else begin
      irq_en_q  <= irq_en_d;
      irq_sts_q <= irq_sts_d;
      run_q     <= run_d;
      srst_q    <= srst_d;
      roi_q     <= roi_d;
      bg_q      <= bg_d;
      src_en_q  <= src_en_d;
    end
  end

  assign irq_o = irq_sts_q & irq_en_q;

endmodule

// File: rtl/lmx_csr_layer.sv
module lmx_csr_layer
  import lmx_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  csr_sel_e    sel,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_q,
  output logic [31:0] size_q,
  output logic [31:0] offs_q,
  output logic [15:0] pitch_q
);

  logic [31:0] ctrl_d, size_d, offs_d;
  logic [15:0] pitch_d;

  always_comb begin
    ctrl_d  = (wr_en && sel == SEL_L_CTRL)  ? wdata        : ctrl_q;
    size_d  = (wr_en && sel == SEL_L_SIZE)  ? wdata        : size_q;
    offs_d  = (wr_en && sel == SEL_L_OFFS)  ? wdata        : offs_q;
    pitch_d = (wr_en && sel == SEL_L_PITCH) ? wdata[15:0]  : pitch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      size_q  <= '0;
      offs_q  <= '0;
      pitch_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      size_q  <= size_d;
      offs_q  <= offs_d;
      pitch_q <= pitch_d;
    end
  end

endmodule

// File: rtl/lmx_csr_rdmux.sv
module lmx_csr_rdmux
  import lmx_csr_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  localparam int LIDX_W    = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
  input  csr_sel_e                 sel,
  input  logic [LIDX_W-1:0]        lidx,
  input  logic                     irq_en,
  input  logic                     irq_sts,
  input  logic                     run,
  input  logic                     srst,
  input  logic [31:0]              roi,
  input  logic [31:0]              bg,
  input  logic [NUM_LAYERS-1:0]    src_en,
  input  logic [32*NUM_LAYERS-1:0] l_ctrl,
  input  logic [32*NUM_LAYERS-1:0] l_size,
  input  logic [32*NUM_LAYERS-1:0] l_offs,
  input  logic [16*NUM_LAYERS-1:0] l_pitch,
  output logic [31:0]              rd_val
);

  always_comb begin
    rd_val = '0;
    unique case (sel)
      SEL_IRQ_EN:  rd_val[FD_BIT] = irq_en;
      SEL_IRQ_STS: rd_val[FD_BIT] = irq_sts;
      SEL_RUN:     rd_val[0]      = run;
      SEL_SRST:    rd_val[0]      = srst;
      SEL_ROI:     rd_val = roi;
      SEL_BG:      rd_val = bg;
      SEL_SRC_EN:  rd_val[NUM_LAYERS-1:0] = src_en;
      SEL_L_CTRL:  rd_val = l_ctrl[32*int'(lidx) +: 32];
      SEL_L_SIZE:  rd_val = l_size[32*int'(lidx) +: 32];
      SEL_L_OFFS:  rd_val = l_offs[32*int'(lidx) +: 32];
      SEL_L_PITCH: rd_val[15:0] = l_pitch[16*int'(lidx) +: 16];
      default:     rd_val = '0;
    endcase
  end

endmodule

// File: rtl/lmx_csr.sv
module lmx_csr
  import lmx_csr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_LAYERS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wen,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_ren,
  output logic [31:0]              bus_rdata,
  input  logic                     frame_done_i,
  output logic                     irq_o,
  output logic                     engine_en_o,
  output logic                     soft_rst_o,
  output logic [31:0]              roi_size_o,
  output logic [31:0]              bg_color_o,
  output logic [NUM_LAYERS-1:0]    src_en_o,
  output logic [32*NUM_LAYERS-1:0] layer_ctrl_o,
  output logic [32*NUM_LAYERS-1:0] layer_size_o,
  output logic [32*NUM_LAYERS-1:0] layer_offs_o,
  output logic [16*NUM_LAYERS-1:0] layer_pitch_o
);

  localparam int LIDX_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1;

  // reset: asserted at once, released two edges later
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  csr_sel_e          sel;
  logic [LIDX_W-1:0] lidx;
  logic              csr_hit;
  logic              irq_en_q, irq_sts_q;
  logic [31:0]       rd_val, rdata_d, rdata_q;

  lmx_csr_decode #(.ADDR_W(ADDR_W), .NUM_LAYERS(NUM_LAYERS)) u_decode (
    .addr (bus_addr),
    .sel  (sel),
    .lidx (lidx)
  );

  assign csr_hit = (sel != SEL_NONE);

  lmx_csr_global #(.NUM_LAYERS(NUM_LAYERS)) u_global (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_en        (bus_wen),
    .sel          (sel),
    .wdata        (bus_wdata),
    .frame_done_i (frame_done_i),
    .irq_en_q     (irq_en_q),
    .irq_sts_q    (irq_sts_q),
    .run_q        (engine_en_o),
    .srst_q       (soft_rst_o),
    .roi_q        (roi_size_o),
    .bg_q         (bg_color_o),
    .src_en_q     (src_en_o),
    .irq_o        (irq_o)
  );

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
    logic bank_wr;
    assign bank_wr = bus_wen && (lidx == LIDX_W'(g));
    lmx_csr_layer u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (bank_wr),
      .sel     (sel),
      .wdata   (bus_wdata),
      .ctrl_q  (layer_ctrl_o[32*g +: 32]),
      .size_q  (layer_size_o[32*g +: 32]),
      .offs_q  (layer_offs_o[32*g +: 32]),
      .pitch_q (layer_pitch_o[16*g +: 16])
    );
  end

  lmx_csr_rdmux #(.NUM_LAYERS(NUM_LAYERS)) u_rdmux (
    .sel     (sel),
    .lidx    (lidx),
    .irq_en  (irq_en_q),
    .irq_sts (irq_sts_q),
    .run     (engine_en_o),
    .srst    (soft_rst_o),
    .roi     (roi_size_o),
    .bg      (bg_color_o),
    .src_en  (src_en_o),
    .l_ctrl  (layer_ctrl_o),
    .l_size  (layer_size_o),
    .l_offs  (layer_offs_o),
    .l_pitch (layer_pitch_o),
    .rd_val  (rd_val)
  );

  always_comb rdata_d = bus_ren ? rd_val : rdata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/lmx_csr_chk.sv
module lmx_csr_chk #(
  parameter int ADDR_W     = 12,
  parameter int NUM_LAYERS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_wen,
  input logic [31:0]              bus_wdata,
  input logic                     bus_ren,
  input logic [31:0]              bus_rdata,
  input logic                     frame_done_i,
  input logic                     irq_o,
  input logic                     irq_en,
  input logic                     irq_sts,
  input logic                     csr_hit,
  input logic                     engine_en_o,
  input logic [31:0]              roi_size_o,
  input logic [31:0]              bg_color_o,
  input logic [NUM_LAYERS-1:0]    src_en_o,
  input logic [32*NUM_LAYERS-1:0] layer_ctrl_o
);

  // R2: read data holds without a strobe
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ren |=> $stable(bus_rdata));

  // R4: an event always leaves the flag set
  assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_i |=> irq_sts);

  // R4: interrupt needs its enable bit
  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en);

  // R5: clearing write without an event empties the flag
  assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == ADDR_W'('h08) && !bus_wdata[1] && !frame_done_i) |=> !irq_sts);

  // R6: run bit follows the written data
  assert_run_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == ADDR_W'('h0C)) |=> (engine_en_o == $past(bus_wdata[0])));

  // R10: writes that miss the map touch nothing
  assert_miss_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && !csr_hit) |=> ($stable(roi_size_o) && $stable(bg_color_o) &&
                               $stable(src_en_o) && $stable(layer_ctrl_o) &&
                               $stable(engine_en_o)));

endmodule

bind lmx_csr lmx_csr_chk #(.ADDR_W(ADDR_W), .NUM_LAYERS(NUM_LAYERS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .bus_addr     (bus_addr),
  .bus_wen      (bus_wen),
  .bus_wdata    (bus_wdata),
  .bus_ren      (bus_ren),
  .bus_rdata    (bus_rdata),
  .frame_done_i (frame_done_i),
  .irq_o        (irq_o),
  .irq_en       (irq_en_q),
  .irq_sts      (irq_sts_q),
  .csr_hit      (csr_hit),
  .engine_en_o  (engine_en_o),
  .roi_size_o   (roi_size_o),
  .bg_color_o   (bg_color_o),
  .src_en_o     (src_en_o),
  .layer_ctrl_o (layer_ctrl_o)
);

// File: tb/lmx_csr_bench.sv
`timescale 1ns/1ps
module lmx_csr_bench;

  localparam int AW = 12;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wen, bus_ren, frame_done_i;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          irq_o, engine_en_o, soft_rst_o;
  logic [31:0]   roi_size_o, bg_color_o;
  logic [NL-1:0] src_en_o;
  logic [32*NL-1:0] layer_ctrl_o, layer_size_o, layer_offs_o;
  logic [16*NL-1:0] layer_pitch_o;

  always #2 clk = ~clk;

  lmx_csr #(.ADDR_W(AW), .NUM_LAYERS(NL)) u_lmx_csr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .frame_done_i(frame_done_i), .irq_o(irq_o), .engine_en_o(engine_en_o),
    .soft_rst_o(soft_rst_o), .roi_size_o(roi_size_o), .bg_color_o(bg_color_o),
    .src_en_o(src_en_o), .layer_ctrl_o(layer_ctrl_o), .layer_size_o(layer_size_o),
    .layer_offs_o(layer_offs_o), .layer_pitch_o(layer_pitch_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  // {is_write, requirement, address, data or expected}
  localparam int NV = 30;
  localparam logic [48:0] VEC [0:NV-1] = '{
    {1'b1, 4'd3,  12'h004, 32'hFFFF_FFFF}, {1'b0, 4'd3,  12'h004, 32'h0000_0002}, // R3
    {1'b1, 4'd6,  12'h00C, 32'h0000_0001}, {1'b0, 4'd6,  12'h00C, 32'h0000_0001}, // R6
    {1'b1, 4'd6,  12'h014, 32'h0000_0003}, {1'b0, 4'd6,  12'h014, 32'h0000_0001}, // R6
    {1'b1, 4'd7,  12'h020, 32'h02D0_0500}, {1'b0, 4'd7,  12'h020, 32'h02D0_0500}, // R7
    {1'b1, 4'd7,  12'h028, 32'h0011_2233}, {1'b0, 4'd7,  12'h028, 32'h0011_2233}, // R7
    {1'b1, 4'd8,  12'h02C, 32'hFFFF_FFFF}, {1'b0, 4'd8,  12'h02C, 32'h0000_000F}, // R8
    {1'b1, 4'd8,  12'h02C, 32'h0000_0005}, {1'b0, 4'd8,  12'h02C, 32'h0000_0005}, // R8
    {1'b1, 4'd9,  12'h030, 32'h2000_ABCD}, {1'b0, 4'd9,  12'h030, 32'h2000_ABCD}, // R9
    {1'b1, 4'd9,  12'h058, 32'h0100_0200}, {1'b0, 4'd9,  12'h058, 32'h0100_0200}, // R9
    {1'b1, 4'd9,  12'h09C, 32'h0010_0020}, {1'b0, 4'd9,  12'h09C, 32'h0010_0020}, // R9
    {1'b1, 4'd9,  12'h0A4, 32'hDEAD_BEEF}, {1'b0, 4'd9,  12'h0A4, 32'h0000_BEEF}, // R9
    {1'b1, 4'd10, 12'h0B0, 32'h1234_5678}, {1'b0, 4'd10, 12'h0B0, 32'h0000_0000}, // R10
    {1'b1, 4'd10, 12'h010, 32'hFFFF_FFFF}, {1'b0, 4'd10, 12'h010, 32'h0000_0000}, // R10
    {1'b1, 4'd10, 12'h034, 32'h0000_0001}, {1'b0, 4'd10, 12'h034, 32'h0000_0000}, // R10
    {1'b1, 4'd10, 12'h031, 32'h7777_7777}, {1'b0, 4'd10, 12'h030, 32'h2000_ABCD}  // R10
  };

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wen = 1'b0; bus_ren = 1'b0;
    bus_wdata = '0; frame_done_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h020, d); chk("R1 roi after reset", d, 32'h0);
    chk("R1 run after reset", {31'b0, engine_en_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) wr(VEC[i][43:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][43:32], d);
        chk($sformatf("R%0d vector %0d", VEC[i][47:44], i), d, VEC[i][31:0]);
      end
    end

    // outputs after the table
    chk("R6 engine_en_o", {31'b0, engine_en_o}, 32'h1);
    chk("R6 soft_rst_o", {31'b0, soft_rst_o}, 32'h1);
    chk("R8 src_en_o after unmapped writes", {28'b0, src_en_o}, 32'h5);
    chk("R7 roi_size_o", roi_size_o, 32'h02D0_0500);
    chk("R9 layer0 ctrl out", layer_ctrl_o[31:0], 32'h2000_ABCD);
    chk("R9 layer3 pitch out", {16'b0, layer_pitch_o[63:48]}, 32'h0000_BEEF);
    chk("R9 layer1 size out", layer_size_o[63:32], 32'h0100_0200);

    // R4: event with enable clear
    wr(12'h004, 32'h0);
    @(negedge clk); frame_done_i = 1'b1;
    @(negedge clk); frame_done_i = 1'b0;
    chk("R4 irq masked", {31'b0, irq_o}, 32'h0);
    rd(12'h008, d); chk("R4 flag set while masked", d, 32'h2);
    wr(12'h004, 32'h2);
    chk("R4 irq after enable", {31'b0, irq_o}, 32'h1);

    // R5: write of 1 keeps, write of 0 clears
    wr(12'h008, 32'h2);
    chk("R5 keep on bit1=1", {31'b0, irq_o}, 32'h1);
    wr(12'h008, 32'h0);
    chk("R5 cleared irq", {31'b0, irq_o}, 32'h0);
    rd(12'h008, d); chk("R5 cleared flag", d, 32'h0);

    // R5: event and clear on the same edge
    @(negedge clk);
    bus_addr = 12'h008; bus_wdata = 32'h0; bus_wen = 1'b1; frame_done_i = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; frame_done_i = 1'b0;
    chk("R5 collision irq", {31'b0, irq_o}, 32'h1);
    rd(12'h008, d); chk("R5 collision flag", d, 32'h2);

    // R2: read and write on one edge return the old value; hold without strobe
    @(negedge clk);
    bus_addr = 12'h028; bus_wdata = 32'h0000_0099; bus_wen = 1'b1; bus_ren = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; bus_ren = 1'b0;
    chk("R2 read-before-write", bus_rdata, 32'h0011_2233);
    bus_addr = 12'h020;
    @(negedge clk);
    chk("R2 hold without strobe", bus_rdata, 32'h0011_2233);
    rd(12'h028, d); chk("R2 new value", d, 32'h0000_0099);

    // R1: reset again in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 irq cleared", {31'b0, irq_o}, 32'h0);
    chk("R1 mask cleared", {28'b0, src_en_o}, 32'h0);
    chk("R1 pitch cleared", {16'b0, layer_pitch_o[63:48]}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(12'h030, d); chk("R1 layer ctrl after reset", d, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule